// File: doc/BRIEF.md
# Receive Queue Release and Overrun Control

This block sits between a host command port and the message queue of a receive path. It tracks how many complete messages wait in the queue. It retires the oldest one when the host issues a release command. It keeps a sticky status bit for data overrun, which the host clears with its own command. Two one-cycle interrupt pulses tell the host that a message has become readable or that an overrun happened. Each pulse has its own enable input.

The host issues commands by raising `cmdWe` for one cycle, together with any mix of the release and clear-overrun strobes. Both strobes may come in the same write. The receive path reports a newly stored message with `pushIn` and a lost message with `overrunEvent`. Message contents are not held here; the queue is modelled as a count of messages. The release logic re-fires the receive interrupt whenever another message is already queued behind the one being retired. The overrun interrupt stays silent for as long as the overrun status bit remains set.

All outputs are registered. An input applied before a clock edge is reflected in the outputs just after that edge.

Top module: `rxq_release_ctrl`

## Requirements
- R1: After reset, `msgCount` is 0 and `rxBufferStatus`, `overrunStatus`, `rxIrq` and `overrunIrq` are all 0.
- R2: A release (`cmdWe` and `cmdRelease` high) while `msgCount` is non-zero lowers the count by one at the next edge, or leaves it unchanged when `pushIn` is high in the same cycle.
- R3: When a release leaves at least one message queued, `rxBufferStatus` stays 1 and `rxIrq` pulses for one cycle if `rxIntEnable` is high. This covers a release with two or more queued messages, and a release of the last message with `pushIn` in the same cycle.
- R4: When a release retires the last message and no push comes with it, `rxBufferStatus` drops to 0 and `rxIrq` stays 0.
- R5: A release while `msgCount` is 0 changes nothing and raises no `rxIrq`.
- R6: A push into an empty queue sets `rxBufferStatus` and pulses `rxIrq` if enabled. A push into a non-empty queue raises no `rxIrq`. A push while the count equals DEPTH, with no release in the same cycle, is dropped.
- R7: `overrunEvent` sets `overrunStatus`. `overrunIrq` pulses only if `overrunIntEnable` is high and the status bit was clear, or was being cleared in the same cycle. An overrun while the bit stays set raises no pulse.
- R8: A clear-overrun command (`cmdWe` and `cmdClearOverrun` high) clears `overrunStatus` at the next edge, unless `overrunEvent` comes in the same cycle; in that case the bit stays 1.
- R9: A single write carrying both release and clear-overrun performs both actions in the same cycle.
- R10: The interrupt enables gate only the pulses. With `rxIntEnable` low, `rxIrq` stays 0. With `overrunIntEnable` low, `overrunIrq` stays 0. Counts and status bits still update in both cases.
- R11: `cmdRelease` and `cmdClearOverrun` have no effect while `cmdWe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWe | input | 1 | Command write strobe, qualifies the two command bits |
| cmdRelease | input | 1 | Release the oldest queued message |
| cmdClearOverrun | input | 1 | Clear the overrun status bit |
| pushIn | input | 1 | Receive path stored one more complete message |
| overrunEvent | input | 1 | Receive path lost a message |
| rxIntEnable | input | 1 | Enables the receive interrupt pulse |
| overrunIntEnable | input | 1 | Enables the overrun interrupt pulse |
| msgCount | output | CNT_W | Number of queued messages |
| rxBufferStatus | output | 1 | At least one message is readable |
| overrunStatus | output | 1 | Sticky data overrun flag |
| rxIrq | output | 1 | One-cycle receive interrupt pulse |
| overrunIrq | output | 1 | One-cycle overrun interrupt pulse |

## Verification
Two pairs of actions can collide in one cycle. The first is a release together with an arriving push, which decides whether the buffer drains or a fresh interrupt fires. The second is a clear-overrun write together with a new overrun event, which decides whether the status bit survives and whether a pulse escapes suppression. Directed steps force each collision with the queue at one message and with the status bit already set. Random stimulus then keeps raising the strobes together at high rates. Every cycle's count, status bits and both pulses are compared against a bench model that resolves the collisions according to R3, R7 and R8.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes issued by the control to the datapath for one cycle.
  typedef struct packed {
    logic pop;      // retire oldest message
    logic push;     // accept newly stored message
    logic setOvr;   // set overrun status
    logic clrOvr;   // clear overrun status
    logic fireRx;   // receive interrupt pulse next cycle
    logic fireOvr;  // overrun interrupt pulse next cycle
  } rxqStrobes_t;

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             cmdWe,
  input  logic             cmdRelease,
  input  logic             cmdClearOverrun,
  input  logic             pushIn,
  input  logic             overrunEvent,
  input  logic             rxIntEnable,
  input  logic             overrunIntEnable,
  input  logic [CNT_W-1:0] msgCount,
  input  logic             overrunStatus,
  output rxqStrobes_t      strobes
);

  localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_COUNT  = CNT_W'(1);

  logic releaseReq;
  logic clearReq;
  logic queueEmpty;
  logic queueFull;
  logic popOk;
  logic pushOk;
  logic moreAfterPop;

  always_comb begin
    releaseReq   = cmdWe & cmdRelease;
    clearReq     = cmdWe & cmdClearOverrun;
    queueEmpty   = (msgCount == '0);
    queueFull    = (msgCount == FULL_COUNT);
    popOk        = releaseReq & ~queueEmpty;
    pushOk       = pushIn & (~queueFull | popOk);
    moreAfterPop = (msgCount > ONE_COUNT) | pushOk;

    strobes.pop     = popOk;
    strobes.push    = pushOk;
    strobes.setOvr  = overrunEvent;
    strobes.clrOvr  = clearReq;
    strobes.fireRx  = rxIntEnable &
                      ((queueEmpty & pushOk) | (popOk & moreAfterPop));
    strobes.fireOvr = overrunIntEnable & overrunEvent &
                      (~overrunStatus | clearReq);
  end

endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobes_t      strobes,
  output logic [CNT_W-1:0] msgCount,
  output logic             overrunStatus,
  output logic             rxIrq,
  output logic             overrunIrq
);

  logic [CNT_W-1:0] countNext;

  always_comb begin
    unique case ({strobes.pop, strobes.push})
      2'b10:   countNext = msgCount - 1'b1;
      2'b01:   countNext = msgCount + 1'b1;
      default: countNext = msgCount;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgCount      <= '0;
      overrunStatus <= 1'b0;
      rxIrq         <= 1'b0;
      overrunIrq    <= 1'b0;
    end else begin
      msgCount <= countNext;
      if (strobes.setOvr)      overrunStatus <= 1'b1;
      else if (strobes.clrOvr) overrunStatus <= 1'b0;
      rxIrq      <= strobes.fireRx;
      overrunIrq <= strobes.fireOvr;
    end
  end

endmodule

// File: rtl/rxq_release_ctrl.sv
module rxq_release_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWe,
  input  logic             cmdRelease,
  input  logic             cmdClearOverrun,
  input  logic             pushIn,
  input  logic             overrunEvent,
  input  logic             rxIntEnable,
  input  logic             overrunIntEnable,
  output logic [CNT_W-1:0] msgCount,
  output logic             rxBufferStatus,
  output logic             overrunStatus,
  output logic             rxIrq,
  output logic             overrunIrq
);

  rxqStrobes_t strobes;

  rxq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .cmdWe            (cmdWe),
    .cmdRelease       (cmdRelease),
    .cmdClearOverrun  (cmdClearOverrun),
    .pushIn           (pushIn),
    .overrunEvent     (overrunEvent),
    .rxIntEnable      (rxIntEnable),
    .overrunIntEnable (overrunIntEnable),
    .msgCount         (msgCount),
    .overrunStatus    (overrunStatus),
    .strobes          (strobes)
  );

  rxq_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .msgCount      (msgCount),
    .overrunStatus (overrunStatus),
    .rxIrq         (rxIrq),
    .overrunIrq    (overrunIrq)
  );

  assign rxBufferStatus = (msgCount != '0);

endmodule

// File: rtl/rxq_release_ctrl_checker.sv
module rxq_release_ctrl_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdWe,
  input logic             cmdRelease,
  input logic             cmdClearOverrun,
  input logic             pushIn,
  input logic             overrunEvent,
  input logic             rxIntEnable,
  input logic             overrunIntEnable,
  input logic [CNT_W-1:0] msgCount,
  input logic             rxBufferStatus,
  input logic             overrunStatus,
  input logic             rxIrq,
  input logic             overrunIrq
);

  logic rel;
  logic clr;
  assign rel = cmdWe & cmdRelease;
  assign clr = cmdWe & cmdClearOverrun;

  // R2
  a_r2_release_decrements: assert property (@(posedge clk) disable iff (!rstN)
    (rel && msgCount != '0 && !pushIn) |=> (msgCount == $past(msgCount) - 1'b1));

  // R3
  a_r3_refire_rx: assert property (@(posedge clk) disable iff (!rstN)
    (rel && msgCount > CNT_W'(1) && rxIntEnable) |=> (rxIrq && rxBufferStatus));

  // R4
  a_r4_drain_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rel && msgCount == CNT_W'(1) && !pushIn) |=> (!rxBufferStatus && !rxIrq));

  // R5
  a_r5_empty_release: assert property (@(posedge clk) disable iff (!rstN)
    (rel && msgCount == '0 && !pushIn) |=> (msgCount == '0 && !rxIrq));

  // R7
  a_r7_ovr_suppressed: assert property (@(posedge clk) disable iff (!rstN)
    (overrunStatus && overrunEvent && !clr) |=> (overrunStatus && !overrunIrq));

  // R8
  a_r8_clear_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (clr && !overrunEvent) |=> !overrunStatus);

  // R10
  a_r10_rx_gate: assert property (@(posedge clk) disable iff (!rstN)
    !rxIntEnable |=> !rxIrq);

  // R10
  a_r10_ovr_gate: assert property (@(posedge clk) disable iff (!rstN)
    !overrunIntEnable |=> !overrunIrq);

  // R11
  a_r11_no_write_no_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWe && !pushIn) |=> ($stable(msgCount)));

  // R6
  a_r6_status_tracks_count: assert property (@(posedge clk) disable iff (!rstN)
    rxBufferStatus == (msgCount != '0));

endmodule

bind rxq_release_ctrl rxq_release_ctrl_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checker (.*);

// File: tb/rxq_release_ctrl_test.sv
module rxq_release_ctrl_test;

  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWe = 1'b0, cmdRelease = 1'b0, cmdClearOverrun = 1'b0;
  logic pushIn = 1'b0, overrunEvent = 1'b0;
  logic rxIntEnable = 1'b1, overrunIntEnable = 1'b1;
  logic [CNT_W-1:0] msgCount;
  logic rxBufferStatus, overrunStatus, rxIrq, overrunIrq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int expCount = 0;
  bit expOvr = 0, expRxIrq = 0, expOvrIrq = 0;

  always #5 clk = ~clk;

  rxq_release_ctrl #(.DEPTH(DEPTH)) uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: cycles %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    checkVal(tag, "msgCount", int'(msgCount), expCount);
    checkVal(tag, "rxBufferStatus", int'(rxBufferStatus), int'(expCount != 0));
    checkVal(tag, "overrunStatus", int'(overrunStatus), int'(expOvr));
    checkVal(tag, "rxIrq", int'(rxIrq), int'(expRxIrq));
    checkVal(tag, "overrunIrq", int'(overrunIrq), int'(expOvrIrq));
  endtask

  // Expected next state, computed from the requirements.
  function automatic void predict();
    bit rel, clr, pop, push;
    rel  = cmdWe && cmdRelease;                       // R11
    clr  = cmdWe && cmdClearOverrun;
    pop  = rel && expCount > 0;                       // R2, R5
    push = pushIn && (expCount < DEPTH || pop);       // R6
    expRxIrq = rxIntEnable &&
               ((expCount == 0 && push) ||            // R6
                (pop && (expCount > 1 || push)));     // R3, R4
    expOvrIrq = overrunIntEnable && overrunEvent && (!expOvr || clr); // R7
    if (overrunEvent) expOvr = 1;                     // R7, R8
    else if (clr) expOvr = 0;
    expCount = expCount - int'(pop) + int'(push);
  endfunction

  // Apply inputs for one cycle, then compare just after the edge.
  task automatic step(string tag, bit we, bit rel, bit clr, bit push, bit ovr,
                      bit rxEn = 1, bit ovrEn = 1);
    cmdWe = we; cmdRelease = rel; cmdClearOverrun = clr;
    pushIn = push; overrunEvent = ovr;
    rxIntEnable = rxEn; overrunIntEnable = ovrEn;
    predict();
    @(posedge clk);
    #2;
    checkAll(tag);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(posedge clk);
    #2;
    checkAll("R1 reset");
    rstN = 1'b1;
    @(posedge clk);
    #2;
    checkAll("R1 after release of reset");

    // R5 release on empty queue
    step("R5 empty release", 1, 1, 0, 0, 0);
    // R6 push into empty fires
    step("R6 push into empty", 0, 0, 0, 1, 0);
    step("R6 push into nonempty", 0, 0, 0, 1, 0);
    step("R6 third push", 0, 0, 0, 1, 0);
    // R3 release with more queued
    step("R3 release refire", 1, 1, 0, 0, 0);
    // R11 strobes without write
    step("R11 no write", 0, 1, 1, 0, 0);
    step("R2 release", 1, 1, 0, 0, 0);
    // R4 drain last
    step("R4 drain last", 1, 1, 0, 0, 0);
    // R3 release of last with concurrent push
    step("R6 refill", 0, 0, 0, 1, 0);
    step("R3 release with push", 1, 1, 0, 1, 0);
    // R6 fill to full then overflow push dropped
    for (int i = 0; i < DEPTH; i++) step("R6 fill", 0, 0, 0, 1, 0);
    step("R6 push at full dropped", 0, 0, 0, 1, 0);
    step("R2 release at full with push", 1, 1, 0, 1, 0);
    // R7 overrun then suppressed
    step("R7 first overrun", 0, 0, 0, 0, 1);
    step("R7 suppressed overrun", 0, 0, 0, 0, 1);
    // R8 clear and event together
    step("R8 clear with event", 1, 0, 1, 0, 1);
    step("R8 clear", 1, 0, 1, 0, 0);
    // R9 both commands in one write
    step("R7 overrun again", 0, 0, 0, 0, 1);
    step("R9 release and clear", 1, 1, 1, 0, 0);
    // R10 enables low
    step("R10 overrun disabled", 0, 0, 0, 0, 1, 1, 0);
    step("R10 release rx disabled", 1, 1, 1, 0, 0, 0, 1);
    for (int i = 0; i < 10; i++) step("R10 drain disabled", 1, 1, 0, 0, 0, 0, 0);
    step("R10 push disabled", 0, 0, 0, 1, 0, 0, 1);

    // Random phase with heavy overlap of strobes.
    for (int i = 0; i < 3000; i++) begin
      bit we, rel, clr, push, ovr, rxEn, ovrEn;
      we    = ($urandom % 4) != 0;
      rel   = ($urandom % 2) == 1;
      clr   = ($urandom % 3) == 0;
      push  = ($urandom % 2) == 1;
      ovr   = ($urandom % 5) == 0;
      rxEn  = ($urandom % 6) != 0;
      ovrEn = ($urandom % 6) != 0;
      step("random R2 R3 R6 R7 R8 R9", we, rel, clr, push, ovr, rxEn, ovrEn);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule